// File: doc/BRIEF.md
# Latched Fault Protection Supervisor

This block is the protection state machine for a synchronous buck power stage. It takes digital flags from the analog comparators: output undervoltage, output overvoltage, output above the reference, a valley overcurrent flag qualified by a strobe once per switching cycle, an instant high-side overcurrent flag, and two temperature flags (hot trip and cooled recovery). From these it sets the switch permissions and the status seen by the rest of the chip: high-side gate enable, low-side force-on, both-switches-off, soft-discharge enable and power-good.

The machine has four states: off, run, latched fault and overvoltage crowbar. Undervoltage, overcurrent and over-temperature trips put it in the latched fault state. There both switches are held off and the output is discharged. An overvoltage trip moves it to the crowbar state. There the high side stays off and the low side follows the output-versus-reference comparator. Nothing leaves a fault state except a falling enable or a loss of the supply-good input, and either one returns the machine to off. After a thermal trip, the stage restarts only when the die has cooled and enable has then been cycled (or supply-good has dropped).

Top module: `fault_supervisor`

## Requirements
- R1: While reset is held, and in the off state, fets_off=1, discharge_en=1, hs_gate_en=0, ls_force_on=0 and pgood=0.
- R2: In run, uv_flag=1 moves the machine to the latched fault state on the next clock edge. From then on fets_off=1, discharge_en=1, hs_gate_en=0 and pgood=0.
- R3: In run, ov_flag=1 with no shutdown fault present moves the machine to the crowbar state on the next clock edge. From then on hs_gate_en=0, pgood=0 and fets_off=0, and discharge_en=0 while en=1.
- R4: In the crowbar state, ls_force_on equals above_ref in the same cycle.
- R5: A valley overcurrent trip needs valley_oc=1 on OC_CYCLES (default 8) consecutive pwm_strobe cycles. A strobe with valley_oc=0 restarts the count from zero. The trip takes effect on the edge of the qualifying strobe.
- R6: Cycles with pwm_strobe=0 neither count toward nor reset the valley streak, whatever valley_oc is.
- R7: In run, hs_oc=1 for a single cycle latches the fault state on the next edge, with no cycle counting.
- R8: In run, ot_hot=1 latches the fault state. The machine then stays in off until ot_cool=1 has been seen and, after that, en has gone low and high again.
- R9: A latched fault or crowbar state persists after the trip flag is removed, for as long as en=1 and por_ok=1.
- R10: discharge_en=1 in every cycle where en=0.
- R11: pgood=1 only in the run state with por_ok=1, en=1 and reg_ok=1 in the same cycle.
- R12: When a shutdown fault (uv, hs_oc, valley trip, hot) and ov_flag arrive in the same run cycle, the latched fault state wins over the crowbar state.
- R13: por_ok=0 returns the machine to off on the next edge from any state. Once por_ok=1 and en=1 again, run resumes without needing an enable toggle (unless a thermal hold is active).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_ok | input | 1 | Supplies above power-on threshold |
| en | input | 1 | Regulation enable |
| reg_ok | input | 1 | Output has reached regulation (start-up ramp done) |
| uv_flag | input | 1 | Output below undervoltage threshold |
| ov_flag | input | 1 | Output above overvoltage threshold |
| above_ref | input | 1 | Output above the reference |
| pwm_strobe | input | 1 | One pulse per switching cycle; qualifies valley_oc |
| valley_oc | input | 1 | Valley current above limit this cycle |
| hs_oc | input | 1 | Catastrophic high-side overcurrent |
| ot_hot | input | 1 | Die above shutdown temperature |
| ot_cool | input | 1 | Die below recovery temperature |
| hs_gate_en | output | 1 | High-side switch permitted |
| ls_force_on | output | 1 | Low-side switch forced on (crowbar) |
| fets_off | output | 1 | Both switches held off |
| discharge_en | output | 1 | Soft-discharge switch on |
| pgood | output | 1 | Power-good status |

## Verification
The hardest condition to reach from the ports is a valley trip on exactly the qualifying strobe. Seven flagged strobes must leave the machine running, a clean strobe must clear the streak, and non-strobe cycles with the flag high must change nothing. Random stimulus almost never lines this up, so a directed sequence interleaves strobed and unstrobed cycles and counts to one short of the limit before crossing it. The thermal restart needs its own ordering: an enable toggle while still hot, then cooling with enable held high, then a second toggle. Random phases with bursty valley flags and rare enable and supply drops then cover the rest of the state space.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RUN     = 2'd1,
    ST_FAULT   = 2'd2,
    ST_CROWBAR = 2'd3
  } sup_state_e;
endpackage

// File: rtl/fsup_valley_qual.sv
module fsup_valley_qual #(
  parameter int OC_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobe,
  input  logic valley_oc,
  output logic trip
);
  localparam int CNT_W = $clog2(OC_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OC_CYCLES - 1);
  localparam logic [CNT_W-1:0] TOP  = CNT_W'(OC_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (strobe) begin
      if (!valley_oc)        cnt_d = '0;
      else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign trip = !clr && strobe && valley_oc && (cnt_q >= LAST);

  // R5: a clean strobe leaves no streak behind for the following cycle
  a_r5_clean_strobe_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && strobe && !valley_oc) |=> (cnt_q == '0));
  // R6: cycles without a strobe leave the streak untouched
  a_r6_no_strobe_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !strobe) |=> $stable(cnt_q));
endmodule

// File: rtl/fsup_restart_gate.sv
module fsup_restart_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  input  logic en,
  input  logic ot_hot,
  input  logic ot_cool,
  input  logic launch,
  output logic start_ok
);
  logic hold_q, hold_d;
  logic arm_q, arm_d;

  always_comb begin
    hold_d = hold_q;
    if (ot_hot)       hold_d = 1'b1;
    else if (ot_cool) hold_d = 1'b0;

    arm_d = arm_q;
    if (!en || !por_ok)     arm_d = 1'b1;
    else if (launch || hold_q) arm_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      arm_q  <= 1'b1;
    end else begin
      hold_q <= hold_d;
      arm_q  <= arm_d;
    end
  end

  assign start_ok = arm_q && !hold_q;

  // R8: an enable that is high while still hot does not arm a restart
  a_r8_hot_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && en && por_ok) |=> !start_ok);
endmodule

// File: rtl/fsup_core.sv
module fsup_core
  import fsup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       por_ok,
  input  logic       en,
  input  logic       start_ok,
  input  logic       uv_flag,
  input  logic       ov_flag,
  input  logic       hs_oc,
  input  logic       ot_hot,
  input  logic       oc_trip,
  output sup_state_e state,
  output logic       launch
);
  sup_state_e state_q, state_d;
  logic       shut;

  assign shut = uv_flag || hs_oc || ot_hot || oc_trip;

  always_comb begin
    state_d = state_q;
    if (!por_ok || !en) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  if (start_ok) state_d = ST_RUN;
        ST_RUN: begin
          if (shut)         state_d = ST_FAULT;
          else if (ov_flag) state_d = ST_CROWBAR;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OFF;
    else        state_q <= state_d;
  end

  assign state  = state_q;
  assign launch = (state_q == ST_OFF) && (state_d == ST_RUN);

  // R9: fault latch holds while enabled and supplied
  a_r9_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FAULT && en && por_ok) |=> (state_q == ST_FAULT));
  // R9: crowbar holds while enabled and supplied
  a_r9_crowbar_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CROWBAR && en && por_ok) |=> (state_q == ST_CROWBAR));
  // R7: instant high-side trip
  a_r7_hs_trip: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && en && por_ok && hs_oc) |=> (state_q == ST_FAULT));
  // R13: supply loss forces off
  a_r13_por_off: assert property (@(posedge clk) disable iff (!rst_n)
    !por_ok |=> (state_q == ST_OFF));
endmodule

// File: rtl/fsup_out_decode.sv
module fsup_out_decode
  import fsup_pkg::*;
(
  input  sup_state_e state,
  input  logic       en,
  input  logic       por_ok,
  input  logic       reg_ok,
  input  logic       above_ref,
  output logic       hs_gate_en,
  output logic       ls_force_on,
  output logic       fets_off,
  output logic       discharge_en,
  output logic       pgood
);
  logic is_run, is_cb, is_dead;

  assign is_run  = (state == ST_RUN);
  assign is_cb   = (state == ST_CROWBAR);
  assign is_dead = (state == ST_OFF) || (state == ST_FAULT);

  assign hs_gate_en   = is_run;
  assign ls_force_on  = is_cb && above_ref;
  assign fets_off     = is_dead;
  assign discharge_en = is_dead || !en;
  assign pgood        = is_run && en && por_ok && reg_ok;

  // R10: discharge whenever disabled
  always_comb begin
    a_r10_discharge_when_off: assert (en || discharge_en);
  end
  // R11: power-good never without its qualifiers
  always_comb begin
    a_r11_pgood_qualified: assert (!pgood || (por_ok && en && reg_ok && !fets_off));
  end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import fsup_pkg::*;
#(
  parameter int OC_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic por_ok,
  input  logic en,
  input  logic reg_ok,
  input  logic uv_flag,
  input  logic ov_flag,
  input  logic above_ref,
  input  logic pwm_strobe,
  input  logic valley_oc,
  input  logic hs_oc,
  input  logic ot_hot,
  input  logic ot_cool,
  output logic hs_gate_en,
  output logic ls_force_on,
  output logic fets_off,
  output logic discharge_en,
  output logic pgood
);
  sup_state_e state;
  logic       oc_trip, start_ok, launch;

  fsup_valley_qual #(.OC_CYCLES(OC_CYCLES)) u_qual (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (state != ST_RUN),
    .strobe    (pwm_strobe),
    .valley_oc (valley_oc),
    .trip      (oc_trip)
  );

  fsup_restart_gate u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_ok   (por_ok),
    .en       (en),
    .ot_hot   (ot_hot),
    .ot_cool  (ot_cool),
    .launch   (launch),
    .start_ok (start_ok)
  );

  fsup_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_ok   (por_ok),
    .en       (en),
    .start_ok (start_ok),
    .uv_flag  (uv_flag),
    .ov_flag  (ov_flag),
    .hs_oc    (hs_oc),
    .ot_hot   (ot_hot),
    .oc_trip  (oc_trip),
    .state    (state),
    .launch   (launch)
  );

  fsup_out_decode u_dec (
    .state        (state),
    .en           (en),
    .por_ok       (por_ok),
    .reg_ok       (reg_ok),
    .above_ref    (above_ref),
    .hs_gate_en   (hs_gate_en),
    .ls_force_on  (ls_force_on),
    .fets_off     (fets_off),
    .discharge_en (discharge_en),
    .pgood        (pgood)
  );

  // R2: undervoltage in run shuts both switches next cycle
  a_r2_uv_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate_en && en && por_ok && uv_flag) |=> (fets_off && discharge_en && !pgood));
  // R3: overvoltage alone enters crowbar without discharge
  a_r3_ov_crowbar: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate_en && en && por_ok && ov_flag && !uv_flag && !hs_oc && !ot_hot && !oc_trip)
      |=> (!hs_gate_en && !fets_off && !pgood));
  // R12: shutdown fault wins over overvoltage
  a_r12_fault_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_gate_en && en && por_ok && ov_flag && uv_flag) |=> fets_off);
endmodule

// File: tb/test_fault_supervisor.sv
module test_fault_supervisor;
  localparam int CLK_PERIOD = 10;
  localparam int OC = 8;
  localparam logic [1:0] M_OFF = 2'd0, M_RUN = 2'd1, M_FLT = 2'd2, M_CB = 2'd3;

  logic clk = 1'b0;
  logic rst_n;
  logic por_ok, en, reg_ok, uv_flag, ov_flag, above_ref;
  logic pwm_strobe, valley_oc, hs_oc, ot_hot, ot_cool;
  logic hs_gate_en, ls_force_on, fets_off, discharge_en, pgood;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [1:0] m_st;
  int         m_cnt;
  logic       m_hold, m_arm;

  always #(CLK_PERIOD/2) clk = ~clk;

  fault_supervisor #(.OC_CYCLES(OC)) i_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en(en), .reg_ok(reg_ok),
    .uv_flag(uv_flag), .ov_flag(ov_flag), .above_ref(above_ref),
    .pwm_strobe(pwm_strobe), .valley_oc(valley_oc), .hs_oc(hs_oc),
    .ot_hot(ot_hot), .ot_cool(ot_cool),
    .hs_gate_en(hs_gate_en), .ls_force_on(ls_force_on), .fets_off(fets_off),
    .discharge_en(discharge_en), .pgood(pgood)
  );

  function automatic logic [4:0] expect_out();
    logic run, cb, dead;
    run  = (m_st == M_RUN);
    cb   = (m_st == M_CB);
    dead = (m_st == M_OFF) || (m_st == M_FLT);
    return {run, cb && above_ref, dead, dead || !en, run && en && por_ok && reg_ok};
  endfunction

  task automatic model_reset();
    m_st = M_OFF; m_cnt = 0; m_hold = 1'b0; m_arm = 1'b1;
  endtask

  task automatic model_step();
    logic [1:0] nx;
    logic trip, shut, start;
    int   cnt_n;
    logic hold_n, arm_n;
    trip  = (m_st == M_RUN) && pwm_strobe && valley_oc && (m_cnt >= OC - 1);
    shut  = uv_flag || hs_oc || ot_hot || trip;
    start = m_arm && !m_hold;
    nx = m_st;
    if (!por_ok || !en) nx = M_OFF;
    else if (m_st == M_OFF && start) nx = M_RUN;
    else if (m_st == M_RUN && shut) nx = M_FLT;
    else if (m_st == M_RUN && ov_flag) nx = M_CB;
    cnt_n = m_cnt;
    if (m_st != M_RUN) cnt_n = 0;
    else if (pwm_strobe) cnt_n = valley_oc ? ((m_cnt < OC) ? m_cnt + 1 : m_cnt) : 0;
    hold_n = ot_hot ? 1'b1 : (ot_cool ? 1'b0 : m_hold);
    arm_n  = m_arm;
    if (!en || !por_ok) arm_n = 1'b1;
    else if ((m_st == M_OFF && nx == M_RUN) || m_hold) arm_n = 1'b0;
    m_st = nx; m_cnt = cnt_n; m_hold = hold_n; m_arm = arm_n;
  endtask

  task automatic compare(input string tag);
    logic [4:0] act, exp;
    act = {hs_gate_en, ls_force_on, fets_off, discharge_en, pgood};
    exp = expect_out();
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs {hs,ls,off,dis,pg} actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input string tag);
    #1;
    compare(tag);
    model_step();
    @(negedge clk);
  endtask

  task automatic quiet();
    uv_flag = 0; ov_flag = 0; above_ref = 0; pwm_strobe = 0;
    valley_oc = 0; hs_oc = 0; ot_hot = 0; ot_cool = 0;
  endtask

  task automatic en_cycle(input string tag);
    en = 0; tick(tag);
    en = 1; tick(tag);
    tick(tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    logic vburst;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    rst_n = 0; por_ok = 1; en = 0; reg_ok = 1; quiet();
    model_reset();
    @(negedge clk);
    #1 compare("R1 reset");
    @(negedge clk);
    #1 compare("R1 reset");
    rst_n = 1;
    tick("R1 off");
    tick("R10 off discharge");
    en = 1; tick("R11 start");
    tick("R11 run pgood");
    reg_ok = 0; tick("R11 not in regulation");
    reg_ok = 1; tick("R11 back in regulation");

    // valley streak: 7 flagged strobes interleaved with unstrobed flagged cycles
    for (int i = 0; i < OC - 1; i++) begin
      pwm_strobe = 1; valley_oc = 1; tick("R5 streak below limit");
      pwm_strobe = 0; valley_oc = (i % 2 == 0); tick("R6 unstrobed cycle");
    end
    pwm_strobe = 1; valley_oc = 0; tick("R5 clean strobe clears");
    for (int i = 0; i < OC - 1; i++) begin
      pwm_strobe = 1; valley_oc = 1; tick("R5 restart streak");
    end
    pwm_strobe = 0; valley_oc = 0; tick("R6 hold streak");
    pwm_strobe = 1; valley_oc = 1; tick("R5 qualifying strobe");
    pwm_strobe = 0; valley_oc = 0; tick("R5 fault latched");
    tick("R9 fault persists");
    tick("R9 fault persists");
    en_cycle("R10 enable toggle");

    hs_oc = 1; tick("R7 hs trip");
    hs_oc = 0; tick("R7 latched");
    tick("R9 hs latch held");
    en_cycle("R10 toggle");

    uv_flag = 1; tick("R2 uv trip");
    uv_flag = 0; tick("R2 latched");
    en_cycle("R10 toggle");

    ov_flag = 1; tick("R3 ov trip");
    ov_flag = 0; above_ref = 1; tick("R4 crowbar above");
    above_ref = 0; tick("R4 crowbar below");
    above_ref = 1; tick("R4 crowbar above again");
    tick("R9 crowbar held");
    en = 0; tick("R10 disable in crowbar");
    en = 1; above_ref = 0; tick("R1 restart");
    tick("R11 run");

    ov_flag = 1; uv_flag = 1; tick("R12 both faults");
    ov_flag = 0; uv_flag = 0; tick("R12 fault wins");
    en_cycle("R10 toggle");

    ot_hot = 1; tick("R8 hot trip");
    tick("R8 latched");
    en_cycle("R8 toggle while hot");
    ot_hot = 0; tick("R8 still hot hold");
    ot_cool = 1; tick("R8 cooled");
    ot_cool = 0; tick("R8 no restart without toggle");
    tick("R8 no restart without toggle");
    en_cycle("R8 toggle after cooling");

    ov_flag = 1; tick("R3 crowbar again");
    ov_flag = 0; por_ok = 0; tick("R13 supply drop");
    tick("R13 off");
    por_ok = 1; tick("R13 resume");
    tick("R13 running");

    vburst = 0;
    for (int c = 0; c < 4000; c++) begin
      quiet();
      if ($urandom_range(0, 29) == 0) vburst = ~vburst;
      pwm_strobe = ($urandom_range(0, 2) == 0);
      valley_oc  = vburst ? ($urandom_range(0, 15) != 0) : ($urandom_range(0, 7) == 0);
      uv_flag    = ($urandom_range(0, 299) == 0);
      ov_flag    = ($urandom_range(0, 199) == 0);
      hs_oc      = ($urandom_range(0, 399) == 0);
      ot_hot     = ($urandom_range(0, 499) == 0);
      ot_cool    = !ot_hot && ($urandom_range(0, 19) == 0);
      above_ref  = $urandom_range(0, 1);
      reg_ok     = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 39) == 0) en = ~en;
      if ($urandom_range(0, 299) == 0) por_ok = 0;
      else if (!por_ok && $urandom_range(0, 3) == 0) por_ok = 1;
      tick("R2-random mix");
    end
    finish_run();
  end
endmodule